// File: doc/BRIEF.md
# DRAM Address Override Register Block

This block lets firmware take direct control of the DRAM address lines A[12:0] and the bank lines BA[1:0]. Firmware uses it while it programs the DRAM mode registers. Two 8-bit control registers hold the pattern to drive and an enable bit. While the enable bit is set, the block drives the stored pattern on the pins. While it is clear, the block releases the pins through their output enable. It also closes an external isolation switch, which gives the bus back to the memory controller.

The registers are reached through a synchronous write port with a combinational read path. Two address windows map onto the same storage, and an input selects which window the current address belongs to. One window stands for a serial management path and the other for an I/O path. A write reaches the pins on the clock edge that captures it, with no commit step. Firmware can therefore set the bank code that selects MR, EMR1, EMR2 or EMR3, set the opcode on A[12:0] and enable driving, then issue the load-mode command through the memory controller.

Top module: `dram_addr_override`

## Requirements
- R1: After reset both registers read 0x00, `dram_a_o` and `dram_ba_o` are zero, `pad_oe_o` is 0 and `sw_close_o` is 1.
- R2: With `bus_sel_i`=0 (serial window), address 0x0080 selects the low register and address 0x0081 selects the high register, for both write and read.
- R3: With `bus_sel_i`=1 (I/O window), address 0xAC10 selects the low register and address 0xAC11 selects the high register. This is the same storage as the serial window.
- R4: Bit n of the low register drives `dram_a_o[n]` for n = 0..7.
- R5: In the high register, bits 4..0 drive `dram_a_o[12:8]`, bit 5 drives `dram_ba_o[0]` and bit 6 drives `dram_ba_o[1]`.
- R6: When bit 7 of the high register (drive enable) is 1, `pad_oe_o` is 1 and `sw_close_o` is 0.
- R7: When the drive-enable bit is 0, `pad_oe_o` is 0 (address and bank pins released) and `sw_close_o` is 1.
- R8: A write with `bus_we_i` high shows on the registers and pins right after the clock edge that samples it.
- R9: Writes to any other address, including a valid address paired with the wrong window select, change nothing. Reads of such addresses return 0x00.
- R10: All four bank codes 00, 01, 10 and 11 (MR, EMR1, EMR2, EMR3) appear on `dram_ba_o` while driving is enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel_i | input | 1 | Window select: 0 serial, 1 I/O |
| bus_addr_i | input | 16 | Register address |
| bus_we_i | input | 1 | Single-cycle write strobe |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Read data for the current address (combinational) |
| dram_a_o | output | 13 | Address pattern for the pads |
| dram_ba_o | output | 2 | Bank pattern for the pads |
| pad_oe_o | output | 1 | Output enable for the address and bank pads |
| sw_close_o | output | 1 | Closes the external bus switch |

## Verification
The hardest case to reach is a cross-window alias. One example is the serial select paired with the I/O address 0xAC10. Another is the I/O select paired with 0x0081. Each is a hit in one window and a miss in the other. The stimulus first loads known nonzero patterns with driving enabled. It then issues writes of different data at these mismatched pairs and at neighbouring addresses (0x0082, 0xAC12, 0x0180). After each write it checks that the pins, the enables and the readback through both windows are unchanged.

// File: rtl/dao_pkg.sv
package dao_pkg;
  localparam int unsigned BUS_AW    = 16;
  localparam int unsigned BUS_DW    = 8;
  localparam int unsigned A_PINS    = 13;
  localparam int unsigned BA_PINS   = 2;
  localparam int unsigned LO_BITS   = BUS_DW;
  localparam int unsigned HI_ABITS  = A_PINS - LO_BITS;
  localparam int unsigned EN_BIT    = BUS_DW - 1;
  localparam int unsigned BA_LSB    = HI_ABITS;

  typedef struct packed {
    logic hit;
    logic upper;
  } win_hit_t;

  // Window hit: base must be even, the pair occupies base and base+1.
  function automatic win_hit_t f_win(input logic [BUS_AW-1:0] addr,
                                     input logic [BUS_AW-1:0] base);
    win_hit_t r;
    r.hit   = (addr[BUS_AW-1:1] == base[BUS_AW-1:1]);
    r.upper = addr[0];
    return r;
  endfunction

  function automatic logic [A_PINS-1:0] f_addr_bus(input logic [BUS_DW-1:0] lo,
                                                   input logic [BUS_DW-1:0] hi);
    return {hi[HI_ABITS-1:0], lo};
  endfunction

  function automatic logic [BA_PINS-1:0] f_bank_bus(input logic [BUS_DW-1:0] hi);
    return hi[BA_LSB +: BA_PINS];
  endfunction
endpackage

// File: rtl/dao_win_decode.sv
module dao_win_decode
  import dao_pkg::*;
#(
  parameter logic [BUS_AW-1:0] SER_BASE = 16'h0080,
  parameter logic [BUS_AW-1:0] IO_BASE  = 16'hAC10
) (
  input  logic              sel_i,
  input  logic [BUS_AW-1:0] addr_i,
  input  logic              we_i,
  output logic              hit_o,
  output logic              upper_o,
  output logic              wr_lo_o,
  output logic              wr_hi_o
);
  win_hit_t ser_w, io_w, pick;

  always_comb begin
    ser_w = f_win(addr_i, SER_BASE);
    io_w  = f_win(addr_i, IO_BASE);
    pick  = sel_i ? io_w : ser_w;
  end

  assign hit_o   = pick.hit;
  assign upper_o = pick.upper;
  assign wr_lo_o = we_i & pick.hit & ~pick.upper;
  assign wr_hi_o = we_i & pick.hit &  pick.upper;
endmodule

// File: rtl/dao_ctrl_regs.sv
module dao_ctrl_regs
  import dao_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_lo_i,
  input  logic              wr_hi_i,
  input  logic [BUS_DW-1:0] wdata_i,
  input  logic              hit_i,
  input  logic              upper_i,
  output logic [BUS_DW-1:0] lo_q,
  output logic [BUS_DW-1:0] hi_q,
  output logic [BUS_DW-1:0] rdata_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q <= '0;
      hi_q <= '0;
    end else begin
      if (wr_lo_i) lo_q <= wdata_i;
      if (wr_hi_i) hi_q <= wdata_i;
    end
  end

  always_comb begin
    rdata_o = '0;
    if (hit_i) rdata_o = upper_i ? hi_q : lo_q;
  end

  // R8: a captured write lands in storage on the next edge
  p_lo_capture_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_lo_i |=> lo_q == $past(wdata_i));
  p_hi_capture_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_hi_i |=> hi_q == $past(wdata_i));
  // R9: storage holds when no decoded write arrives
  p_lo_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_lo_i |=> $stable(lo_q));
  p_hi_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_hi_i |=> $stable(hi_q));
endmodule

// File: rtl/dao_pad_ctrl.sv
module dao_pad_ctrl
  import dao_pkg::*;
(
  input  logic [BUS_DW-1:0]  lo_i,
  input  logic [BUS_DW-1:0]  hi_i,
  output logic [A_PINS-1:0]  a_o,
  output logic [BA_PINS-1:0] ba_o,
  output logic               oe_o,
  output logic               sw_close_o
);
  logic drive_en;

  assign drive_en   = hi_i[EN_BIT];
  assign a_o        = f_addr_bus(lo_i, hi_i);
  assign ba_o       = f_bank_bus(hi_i);
  // Both controls come from one stored bit: they always switch on the same edge.
  assign oe_o       = drive_en;
  assign sw_close_o = ~drive_en;
endmodule

// File: rtl/dram_addr_override.sv
module dram_addr_override
  import dao_pkg::*;
#(
  parameter logic [BUS_AW-1:0] SER_BASE = 16'h0080,
  parameter logic [BUS_AW-1:0] IO_BASE  = 16'hAC10
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bus_sel_i,
  input  logic [BUS_AW-1:0]  bus_addr_i,
  input  logic               bus_we_i,
  input  logic [BUS_DW-1:0]  bus_wdata_i,
  output logic [BUS_DW-1:0]  bus_rdata_o,
  output logic [A_PINS-1:0]  dram_a_o,
  output logic [BA_PINS-1:0] dram_ba_o,
  output logic               pad_oe_o,
  output logic               sw_close_o
);
  logic              dec_hit, dec_upper, wr_lo, wr_hi;
  logic [BUS_DW-1:0] lo_q, hi_q;

  dao_win_decode #(.SER_BASE(SER_BASE), .IO_BASE(IO_BASE)) u_dec (
    .sel_i(bus_sel_i), .addr_i(bus_addr_i), .we_i(bus_we_i),
    .hit_o(dec_hit), .upper_o(dec_upper), .wr_lo_o(wr_lo), .wr_hi_o(wr_hi)
  );

  dao_ctrl_regs u_regs (
    .clk(clk), .rst_n(rst_n), .wr_lo_i(wr_lo), .wr_hi_i(wr_hi),
    .wdata_i(bus_wdata_i), .hit_i(dec_hit), .upper_i(dec_upper),
    .lo_q(lo_q), .hi_q(hi_q), .rdata_o(bus_rdata_o)
  );

  dao_pad_ctrl u_pad (
    .lo_i(lo_q), .hi_i(hi_q), .a_o(dram_a_o), .ba_o(dram_ba_o),
    .oe_o(pad_oe_o), .sw_close_o(sw_close_o)
  );

  // R4: low-register write reaches A[7:0] on the next edge
  p_low_pins_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_lo |=> dram_a_o[LO_BITS-1:0] == $past(bus_wdata_i));
  // R6: enabling drive opens the pads and the switch together
  p_drive_on_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hi && bus_wdata_i[EN_BIT]) |=> (pad_oe_o && !sw_close_o));
  // R7: disabling drive releases the pads and closes the switch
  p_drive_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hi && !bus_wdata_i[EN_BIT]) |=> (!pad_oe_o && sw_close_o));
  // R5: bank pins follow bits 6:5 of the high write
  p_bank_pins_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_hi |=> dram_ba_o == $past(bus_wdata_i[BA_LSB +: BA_PINS]));
endmodule

// File: tb/dram_addr_override_tb_top.sv
module dram_addr_override_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel_i = 1'b0;
  logic [15:0] bus_addr_i = '0;
  logic        bus_we_i = 1'b0;
  logic [7:0]  bus_wdata_i = '0;
  logic [7:0]  bus_rdata_o;
  logic [12:0] dram_a_o;
  logic [1:0]  dram_ba_o;
  logic        pad_oe_o, sw_close_o;

  int n_chk = 0;
  int n_bad = 0;
  logic [7:0] m_lo = '0;
  logic [7:0] m_hi = '0;

  always #2.5 clk = ~clk;

  dram_addr_override dut_i (
    .clk(clk), .rst_n(rst_n), .bus_sel_i(bus_sel_i), .bus_addr_i(bus_addr_i),
    .bus_we_i(bus_we_i), .bus_wdata_i(bus_wdata_i), .bus_rdata_o(bus_rdata_o),
    .dram_a_o(dram_a_o), .dram_ba_o(dram_ba_o), .pad_oe_o(pad_oe_o),
    .sw_close_o(sw_close_o)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Bench-side model of the window map (R2, R3, R9)
  function automatic int model_idx(input logic sel, input logic [15:0] a);
    if (!sel && a == 16'h0080) return 0;
    if (!sel && a == 16'h0081) return 1;
    if ( sel && a == 16'hAC10) return 0;
    if ( sel && a == 16'hAC11) return 1;
    return -1;
  endfunction

  task automatic wr(input logic sel, input logic [15:0] a, input logic [7:0] d);
    int k;
    @(negedge clk);
    bus_sel_i = sel; bus_addr_i = a; bus_wdata_i = d; bus_we_i = 1'b1;
    k = model_idx(sel, a);
    if (k == 0) m_lo = d;
    if (k == 1) m_hi = d;
    @(negedge clk);
    bus_we_i = 1'b0;
  endtask

  task automatic rd(input string tag, input logic sel, input logic [15:0] a, input logic [7:0] exp);
    @(negedge clk);
    bus_sel_i = sel; bus_addr_i = a;
    #1;
    check(tag, {24'h0, bus_rdata_o}, {24'h0, exp});
  endtask

  task automatic pins(input string tag);
    #1;
    check({tag, " A"}, {19'h0, dram_a_o}, {19'h0, m_hi[4:0], m_lo});
    check({tag, " BA"}, {30'h0, dram_ba_o}, {30'h0, m_hi[6:5]});
    check({tag, " OE"}, {31'h0, pad_oe_o}, {31'h0, m_hi[7]});
    check({tag, " SW"}, {31'h0, sw_close_o}, {31'h0, ~m_hi[7]});
  endtask

  task automatic t_reset();
    pins("R1 reset");
    rd("R1 lo", 1'b0, 16'h0080, 8'h00);
    rd("R1 hi", 1'b1, 16'hAC11, 8'h00);
    check("R1 oe", {31'h0, pad_oe_o}, 32'h0);
    check("R1 sw", {31'h0, sw_close_o}, 32'h1);
  endtask

  task automatic t_serial();
    wr(1'b0, 16'h0080, 8'h5A);
    pins("R8 serial lo");
    wr(1'b0, 16'h0081, 8'h93);
    pins("R2 serial hi");
    rd("R2 rd lo", 1'b0, 16'h0080, 8'h5A);
    rd("R2 rd hi", 1'b0, 16'h0081, 8'h93);
    rd("R3 alias lo", 1'b1, 16'hAC10, 8'h5A);
  endtask

  task automatic t_io();
    wr(1'b1, 16'hAC10, 8'hC3);
    wr(1'b1, 16'hAC11, 8'h6E);
    pins("R3 io");
    rd("R3 via serial hi", 1'b0, 16'h0081, 8'h6E);
    rd("R3 via io lo", 1'b1, 16'hAC10, 8'hC3);
  endtask

  task automatic t_walk();
    wr(1'b0, 16'h0081, 8'h80);
    for (int i = 0; i < 8; i++) begin
      wr(1'b1, 16'hAC10, 8'(1 << i));
      pins($sformatf("R4 bit%0d", i));
    end
    for (int i = 0; i < 5; i++) begin
      wr(1'b0, 16'h0081, 8'h80 | 8'(1 << i));
      pins($sformatf("R5 A%0d", i + 8));
    end
  endtask

  task automatic t_banks();
    for (int b = 0; b < 4; b++) begin
      wr(1'b1, 16'hAC11, 8'h80 | 8'(b << 5) | 8'h0A);
      pins($sformatf("R10 code%0d", b));
      check("R10 ba", {30'h0, dram_ba_o}, b);
    end
  endtask

  task automatic t_switch();
    wr(1'b0, 16'h0081, 8'hFF);
    pins("R6 on");
    check("R6 oe", {31'h0, pad_oe_o}, 32'h1);
    wr(1'b0, 16'h0081, 8'h7F);
    pins("R7 off");
    check("R7 sw", {31'h0, sw_close_o}, 32'h1);
    wr(1'b1, 16'hAC11, 8'h80);
    check("R8 oe immediate", {31'h0, pad_oe_o}, 32'h1);
  endtask

  task automatic t_ignored();
    wr(1'b0, 16'h0080, 8'hA5);
    wr(1'b0, 16'h0081, 8'hB6);
    wr(1'b0, 16'hAC10, 8'h11);
    pins("R9 serial sel io addr");
    wr(1'b1, 16'h0081, 8'h22);
    pins("R9 io sel serial addr");
    wr(1'b0, 16'h0082, 8'h33);
    wr(1'b1, 16'hAC12, 8'h44);
    wr(1'b0, 16'h0180, 8'h55);
    pins("R9 neighbours");
    rd("R9 rd miss a", 1'b0, 16'hAC10, 8'h00);
    rd("R9 rd miss b", 1'b1, 16'h0080, 8'h00);
    rd("R9 rd miss c", 1'b0, 16'h007F, 8'h00);
    rd("R9 lo kept", 1'b1, 16'hAC10, 8'hA5);
    rd("R9 hi kept", 1'b0, 16'h0081, 8'hB6);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_serial();
    t_io();
    t_walk();
    t_banks();
    t_switch();
    t_ignored();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(200000 * 5);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule